// File: doc/BRIEF.md
# Compare Timer Frame

This block is a single register frame of a compare timer. A 64-bit system count is supplied from outside and advances on its own. Software programs a 64-bit compare value through a 32-bit register bus, as two 32-bit halves. Once the timer is switched on, the block raises a status flag and can raise a level interrupt when the count reaches or passes the compare value. The test is the signed 64-bit difference between count and compare, so the flag stays correct when the count wraps around.

The same registers can be reached through two views of the bus, selected per access. One is a privileged view and the other is a less-privileged view. Two permission inputs decide whether the timer registers are visible in each view. An access that is refused reads as zero and has no effect on any register.

Top module: `cmp_timer_frame`

## Requirements
- R1: The compare value is 64 bits and can be read and written. Its low half is at byte offset 0x020 and its high half at 0x024, in both views.
- R2: A write to one half of the compare value changes only that half. The other half keeps its value.
- R3: While the enable bit is set, ISTATUS is 1 exactly when (count - compare), taken as a signed 64-bit number, is greater than or equal to zero. This includes the cases where the count has wrapped around.
- R4: While the enable bit is clear, ISTATUS reads 0 and the interrupt is low, whatever the count and compare values are.
- R5: The control register is at offset 0x02C. Bit 0 is the enable, bit 1 is the interrupt mask, and bit 2 is ISTATUS, which is read-only: writes to bit 2 are ignored. The interrupt output is high when enable is 1, ISTATUS is 1 and mask is 0.
- R6: ISTATUS is a registered copy of the timer condition. After a write to the compare value, ISTATUS takes its new value at the next clock edge, not at the edge of the write itself.
- R7: In the privileged view (view select 0), the timer registers can be reached only while the physical-timer permission input is 1. Otherwise reads return 0 and writes change nothing.
- R8: In the less-privileged view (view select 1), the timer registers can be reached only while both the physical-timer permission input and the less-privileged enable input are 1. Otherwise reads return 0 and writes change nothing.
- R9: After reset, the control register reads 0 and the interrupt is low.
- R10: Offsets in the frame that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Free-running system count |
| view_sel_i | input | 1 | 0 selects the privileged view, 1 selects the less-privileged view |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Byte offset within the frame |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| perm_phys_i | input | 1 | Physical-timer permission for the privileged view |
| perm_low_i | input | 1 | Extra enable for the less-privileged view |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are the wrap-around cases. In these, the unsigned order of count and compare disagrees with the signed difference: a count of zero against a compare with the top bit set, and an all-ones count against a compare of zero. The vector table writes each compare half through the bus, drives the count directly, and checks ISTATUS and the interrupt one edge later. The single-cycle latency of ISTATUS is observed at the sample point between the write edge and the following edge.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned CNT_W   = 64;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned CV_WORDS = CNT_W / BUS_W;
  localparam int unsigned WORD_BYTES = BUS_W / 8;

  localparam logic [ADDR_W-1:0] OFF_CVAL = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h02C;

  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_MASK = 1;
  localparam int unsigned CTL_STAT = 2;

  typedef enum logic {
    VIEW_PRIV = 1'b0,
    VIEW_LOW  = 1'b1
  } view_e;

  typedef struct packed {
    logic mask;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cmp_rst_sync.sv
module cmp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmp_access_gate.sv
module cmp_access_gate
  import cmp_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic view_sel_i,
  input  logic perm_phys_i,
  input  logic perm_low_i,
  output logic acc_ok_o
);
  logic priv_ok;
  logic low_ok;

  always_comb begin
    priv_ok = perm_phys_i;
    low_ok  = priv_ok & perm_low_i;
    acc_ok_o = (view_e'(view_sel_i) == VIEW_LOW) ? low_ok : priv_ok;
  end

  // R8
  low_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (view_sel_i && acc_ok_o) |-> (perm_phys_i && perm_low_i));

  // R7
  priv_needs_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!view_sel_i && !perm_phys_i) |-> !acc_ok_o);
endmodule

// File: rtl/cmp_regfile.sv
module cmp_regfile
  import cmp_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              acc_ok_i,
  input  logic              status_i,
  output logic [CNT_W-1:0]  cval_o,
  output ctrl_t             ctrl_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [CNT_W-1:0]    cval_q;
  logic [CNT_W-1:0]    cval_d;
  logic [CV_WORDS-1:0] cv_hit;
  logic                ctrl_hit;
  ctrl_t               ctrl_q;
  ctrl_t               ctrl_d;
  logic                wr_ok;

  assign wr_ok = wr_en_i & acc_ok_i;

  genvar gi;
  generate
    for (gi = 0; gi < CV_WORDS; gi++) begin : g_cv_word
      assign cv_hit[gi] = (addr_i == OFF_CVAL + ADDR_W'(gi * WORD_BYTES));

      always_comb begin
        if (wr_ok && cv_hit[gi]) cval_d[gi*BUS_W +: BUS_W] = wdata_i;
        else                     cval_d[gi*BUS_W +: BUS_W] = cval_q[gi*BUS_W +: BUS_W];
      end
    end
  endgenerate

  assign ctrl_hit = (addr_i == OFF_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok && ctrl_hit) begin
      ctrl_d.en   = wdata_i[CTL_EN];
      ctrl_d.mask = wdata_i[CTL_MASK];
    end
  end

  always_ff @(posedge clk) begin
    cval_q <= cval_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i && acc_ok_i) begin
      for (int i = 0; i < CV_WORDS; i++) begin
        if (cv_hit[i]) rdata_o = cval_q[i*BUS_W +: BUS_W];
      end
      if (ctrl_hit) begin
        rdata_o[CTL_EN]   = ctrl_q.en;
        rdata_o[CTL_MASK] = ctrl_q.mask;
        rdata_o[CTL_STAT] = status_i;
      end
    end
  end

  assign cval_o = cval_q;
  assign ctrl_o = ctrl_q;

  // R7
  blocked_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !acc_ok_i) |=> $stable(ctrl_q));

  // R2
  low_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cv_hit[0]) |=> (cval_q[CNT_W-1:BUS_W] === $past(cval_q[CNT_W-1:BUS_W])));

  // R2
  high_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cv_hit[CV_WORDS-1]) |=> (cval_q[BUS_W-1:0] === $past(cval_q[BUS_W-1:0])));
endmodule

// File: rtl/cmp_condition.sv
module cmp_condition
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cval_i,
  input  logic             en_i,
  output logic             status_o
);
  logic [CNT_W-1:0] diff;
  logic             cond;
  logic             status_q;

  always_comb begin
    diff = count_i - cval_i;
    cond = en_i & ~diff[CNT_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= cond;
  end

  assign status_o = status_q;

  // R4
  off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !status_q);

  // R3
  equal_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && count_i == cval_i) |=> status_q);
endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame
  import cmp_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              view_sel_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              perm_phys_i,
  input  logic              perm_low_i,
  output logic              irq_o
);
  logic             rst_sync_n;
  logic             acc_ok;
  logic [CNT_W-1:0] cval;
  ctrl_t            ctrl;
  logic             status;

  cmp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmp_access_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .view_sel_i  (view_sel_i),
    .perm_phys_i (perm_phys_i),
    .perm_low_i  (perm_low_i),
    .acc_ok_o    (acc_ok)
  );

  cmp_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .acc_ok_i (acc_ok),
    .status_i (status),
    .cval_o   (cval),
    .ctrl_o   (ctrl),
    .rdata_o  (rdata_o)
  );

  cmp_condition u_cond (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .count_i  (count_i),
    .cval_i   (cval),
    .en_i     (ctrl.en),
    .status_o (status)
  );

  assign irq_o = ctrl.en & status & ~ctrl.mask;

  // R7
  refused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en_i && !acc_ok) |-> (rdata_o == '0));

  // R5
  mask_silences_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_o) |-> (status && !ctrl.mask));
endmodule

// File: tb/cmp_timer_frame_test.sv
`timescale 1ns/1ps
module cmp_timer_frame_test;
  logic        clk;
  logic        rst_n;
  logic [63:0] count;
  logic        view_sel;
  logic        wr_en;
  logic        rd_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        perm_phys;
  logic        perm_low;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cmp_timer_frame uut (
    .clk(clk), .rst_n(rst_n), .count_i(count), .view_sel_i(view_sel),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .perm_phys_i(perm_phys), .perm_low_i(perm_low), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {count, compare, expected ISTATUS}
  localparam logic [128:0] VEC [8] = '{
    {64'd100, 64'd100, 1'b1},
    {64'd99, 64'd100, 1'b0},
    {64'd101, 64'd100, 1'b1},
    {64'h0, 64'h8000_0000_0000_0001, 1'b1},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0},
    {64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b1},
    {64'h1234_5678_0000_0000, 64'h1234_5679_0000_0000, 1'b0},
    {64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic v, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    view_sel = v; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic v, input logic [11:0] a, output logic [31:0] d);
    view_sel = v; addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic set_cval(input logic [63:0] c);
    bus_wr(1'b0, 12'h020, c[31:0]);
    bus_wr(1'b0, 12'h024, c[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; count = '0; view_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; perm_phys = 1'b1; perm_low = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check("R9 irq", irq, 0);
    bus_rd(1'b0, 12'h02C, rd);
    check("R9 ctrl", rd, 0);

    // R3/R5 vector table
    bus_wr(1'b0, 12'h02C, 32'h1);
    for (int i = 0; i < 8; i++) begin
      count = VEC[i][128:65];
      set_cval(VEC[i][64:1]);
      @(negedge clk);
      bus_rd(1'b0, 12'h02C, rd);
      check($sformatf("R3 vec%0d istatus", i), rd[2], VEC[i][0]);
      check($sformatf("R5 vec%0d irq", i), irq, VEC[i][0]);
    end

    // R1 readback in both views
    set_cval(64'hDEAD_BEEF_0123_4567);
    bus_rd(1'b0, 12'h020, rd); check("R1 lo priv", rd, 32'h0123_4567);
    bus_rd(1'b0, 12'h024, rd); check("R1 hi priv", rd, 32'hDEAD_BEEF);
    bus_rd(1'b1, 12'h024, rd); check("R1 hi low view", rd, 32'hDEAD_BEEF);

    // R2 half write
    bus_wr(1'b1, 12'h020, 32'h1111_1111);
    bus_rd(1'b0, 12'h024, rd); check("R2 hi kept", rd, 32'hDEAD_BEEF);
    bus_rd(1'b0, 12'h020, rd); check("R2 lo new", rd, 32'h1111_1111);
    bus_wr(1'b0, 12'h024, 32'h2222_2222);
    bus_rd(1'b0, 12'h020, rd); check("R2 lo kept", rd, 32'h1111_1111);

    // R6 latency
    count = 64'd1000;
    set_cval(64'd2000);
    @(negedge clk);
    check("R6 before", irq, 0);
    bus_wr(1'b0, 12'h020, 32'd1000);
    check("R6 write edge", irq, 0);
    @(negedge clk);
    check("R6 next edge", irq, 1);

    // R5 mask and read-only status
    bus_wr(1'b0, 12'h02C, 32'h3);
    @(negedge clk);
    bus_rd(1'b0, 12'h02C, rd); check("R5 masked ctrl", rd, 32'h7);
    check("R5 masked irq", irq, 0);

    // R4 disable
    count = 64'd5000;
    bus_wr(1'b0, 12'h02C, 32'h4);
    check("R4 irq off", irq, 0);
    @(negedge clk);
    bus_rd(1'b0, 12'h02C, rd); check("R4 status off R5 ro bit", rd, 32'h0);

    // R7 privileged view gating
    bus_wr(1'b0, 12'h02C, 32'h1);
    @(negedge clk);
    perm_phys = 1'b0;
    bus_rd(1'b0, 12'h020, rd); check("R7 read zero", rd, 0);
    bus_wr(1'b0, 12'h020, 32'hAAAA_AAAA);
    bus_wr(1'b0, 12'h02C, 32'h0);
    perm_phys = 1'b1;
    bus_rd(1'b0, 12'h020, rd); check("R7 cval kept", rd, 32'd1000);
    bus_rd(1'b0, 12'h02C, rd); check("R7 ctrl kept", rd, 32'h5);
    check("R7 irq kept", irq, 1);

    // R8 less-privileged view gating
    perm_low = 1'b0;
    bus_rd(1'b1, 12'h024, rd); check("R8 no low enable", rd, 0);
    bus_wr(1'b1, 12'h024, 32'h5555_5555);
    perm_low = 1'b1; perm_phys = 1'b0;
    bus_rd(1'b1, 12'h024, rd); check("R8 no phys perm", rd, 0);
    perm_phys = 1'b1;
    bus_rd(1'b1, 12'h024, rd); check("R8 both set", rd, 32'h0);
    bus_rd(1'b1, 12'h020, rd); check("R8 both lo", rd, 32'd1000);

    // R10 unmapped
    bus_rd(1'b0, 12'h028, rd); check("R10 0x028", rd, 0);
    bus_rd(1'b0, 12'h000, rd); check("R10 0x000", rd, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule